// File: doc/BRIEF.md
# Asynchronous EPROM Read Sequencer

This block lets synchronous logic read a 4096 x 8 asynchronous, UV-erasable EPROM. The host raises a request with a 12-bit word address. The sequencer latches the address and drives it to the part. It pulls the active-low chip select low, then pulls the active-low output gate low at the last moment that still meets the access time. It samples the byte once the access time has passed and returns it with a one-cycle valid strobe.

After each sample both enables go high again, so the part falls back to standby and stops driving its pins. The sequencer then holds a busy flag for a float window. During that window no other access can start, and so no other device on a shared data bus can drive it while this part is still releasing it.

The three analog timings are parameters in nanoseconds, together with the clock period. Each one is rounded up to whole clock cycles: ACC_CYC for the access time, OE_CYC for the gate-to-data time and DF_CYC for the float time.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, and for as long as reset is held, both enables are high and busy, rvalid and rdata are all zero.
- R2: The output gate is low only in cycles in which the chip select is also low.
- R3: If req is high while busy is low, the request is accepted at that clock edge. From the next cycle on, the chip select is low, busy is high and the device address equals the requested address.
- R4: The output gate falls G_DLY = ACC_CYC − OE_CYC cycles after the chip select, where each cycle count is the nanosecond value divided by the clock period and rounded up.
- R5: The byte on the data bus is sampled at the edge that ends the ACC_CYC-th cycle of chip select low. rvalid is high for exactly the next cycle and carries that byte, and both enables are already high in that cycle.
- R6: The device address stays constant from one accepted request until the next accepted request, so it is held through the sample edge.
- R7: Busy stays high for DF_CYC cycles, counting the rvalid cycle. The chip select therefore stays high for at least DF_CYC + 1 cycles between two accesses.
- R8: A request made while busy is high starts no access and does not change the device address. A request held high is taken in the first cycle in which busy is low.
- R9: rdata keeps its last returned value until the next rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Read request |
| addr_i | input | ADDR_W | Word address of the request |
| busy_o | output | 1 | High from acceptance until the float window has passed |
| rdata_o | output | DATA_W | Last byte read |
| rvalid_o | output | 1 | One-cycle strobe: rdata_o is new |
| mem_addr_o | output | ADDR_W | Address to the device |
| mem_ce_n_o | output | 1 | Device chip select, active low |
| mem_oe_n_o | output | 1 | Device output gate, active low |
| mem_q_i | input | DATA_W | Data bus from the device |

## Verification
A new request can arrive in the same cycle as the result strobe, or in the last cycle of the float window. In both cases the request must be held off while the finished read still completes. The bench provokes both by keeping a second request high with a different address through a whole read. It then judges the outcome at the ports: the first byte must be correct, the device address must stay at the old value, and the chip select must stay high for exactly DF_CYC + 1 cycles before the held request is accepted. The bench also reads every address, and its memory model returns a wrong byte whenever the access or gate time is cut short.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
// Shared types and timing helpers for the EPROM read sequencer.
// Assumes all timing values are positive integers in nanoseconds.
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } rd_state_e;

    // Converts a time in ns to whole clock cycles, rounding up.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    // Returns the larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Returns the smaller of two integers.
    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
`timescale 1ns/1ps
// Cycle counter shared by the access and float phases.
// Assumes the sequencer clears it at each phase boundary.
module eprom_rd_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    // Counts cycles within the current phase, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/eprom_rd_seq.sv
`timescale 1ns/1ps
// Phase sequencer: idle, access, float. Drives both device enables.
// Assumes 0 <= G_DLY < ACC_CYC and DF_CYC >= 1.
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int ACC_CYC = 20,
    parameter int G_DLY   = 10,
    parameter int DF_CYC  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             busy_o,
    output logic             ce_n_o,
    output logic             oe_n_o
);

    localparam logic [CNT_W-1:0] LAST_ACC   = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_DF    = CNT_W'(DF_CYC - 1);
    localparam bit               OE_WITH_CE = (G_DLY == 0);
    localparam logic [CNT_W-1:0] OE_AT      = CNT_W'(OE_WITH_CE ? 0 : G_DLY - 1);

    rd_state_e state_q, state_d;
    logic      accept, capture, float_done, oe_due;
    logic      ce_n_q, oe_n_q;

    // Decodes the phase events from the state and the cycle count.
    always_comb begin
        accept     = (state_q == ST_IDLE) && req_i;
        capture    = (state_q == ST_ACCESS) && (cnt_i == LAST_ACC);
        float_done = (state_q == ST_FLOAT) && (cnt_i == LAST_DF);
        oe_due     = (state_q == ST_ACCESS) && !OE_WITH_CE && (cnt_i == OE_AT);
    end

    // Chooses the next phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)     state_d = ST_ACCESS;
            ST_ACCESS: if (capture)    state_d = ST_FLOAT;
            ST_FLOAT:  if (float_done) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Holds the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Chip select: low from acceptance to the sample edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
        end else if (accept) begin
            ce_n_q <= 1'b0;
        end else if (capture) begin
            ce_n_q <= 1'b1;
        end
    end

    // Output gate: low from G_DLY cycles after the select to the sample edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_n_q <= 1'b1;
        end else if (accept) begin
            oe_n_q <= !OE_WITH_CE;
        end else if (capture) begin
            oe_n_q <= 1'b1;
        end else if (oe_due) begin
            oe_n_q <= 1'b0;
        end
    end

    assign cnt_clr_o = (state_q == ST_IDLE) || capture || float_done;
    assign accept_o  = accept;
    assign capture_o = capture;
    assign busy_o    = (state_q != ST_IDLE);
    assign ce_n_o    = ce_n_q;
    assign oe_n_o    = oe_n_q;

endmodule

// File: rtl/eprom_rd_path.sv
`timescale 1ns/1ps
// Address and data registers with the result strobe.
// Assumes the device bus is settled at each capture edge.
module eprom_rd_path #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] mem_q_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    // Latches the request address; held until the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept_i) begin
            addr_q <= addr_i;
        end
    end

    // Samples the device bus at the end of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture_i) begin
            rdata_q <= mem_q_i;
        end
    end

    // Raises the result strobe for the one cycle after the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture_i;
        end
    end

    assign mem_addr_o = addr_q;
    assign rdata_o    = rdata_q;
    assign rvalid_o   = rvalid_q;

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
// Read sequencer for an asynchronous 4K x 8 EPROM.
// Turns the nanosecond timings into rounded-up cycle counts and wires the
// timer, sequencer and register path together.
// Assumes the device data bus is used only by this block or by parts whose
// selects are exclusive.
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_ACC_NS = 200,
    parameter int T_OE_NS  = 100,
    parameter int T_DF_NS  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    input  logic [DATA_W-1:0] mem_q_i
);

    localparam int ACC_CYC = imax(1, ns_to_cyc(T_ACC_NS, CLK_NS));
    localparam int OE_CYC  = imin(ACC_CYC, imax(1, ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int DF_CYC  = imax(1, ns_to_cyc(T_DF_NS, CLK_NS));
    localparam int G_DLY   = ACC_CYC - OE_CYC;
    localparam int CNT_W   = $clog2(imax(ACC_CYC, DF_CYC) + 1);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr, accept, capture;

    eprom_rd_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    eprom_rd_seq #(
        .CNT_W   (CNT_W),
        .ACC_CYC (ACC_CYC),
        .G_DLY   (G_DLY),
        .DF_CYC  (DF_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .cnt_i     (cnt),
        .cnt_clr_o (cnt_clr),
        .accept_o  (accept),
        .capture_o (capture),
        .busy_o    (busy_o),
        .ce_n_o    (mem_ce_n_o),
        .oe_n_o    (mem_oe_n_o)
    );

    eprom_rd_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .capture_i  (capture),
        .addr_i     (addr_i),
        .mem_q_i    (mem_q_i),
        .mem_addr_o (mem_addr_o),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o)
    );

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for eprom_rd_ctrl, attached by bind.
// Counts select-low, gate-low and select-high run lengths and relates them
// to the rounded-up cycle counts.
module eprom_rd_ctrl_chk
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_ACC_NS = 200,
    parameter int T_OE_NS  = 100,
    parameter int T_DF_NS  = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              busy_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o,
    input logic [DATA_W-1:0] mem_q_i
);

    localparam int ACC_CYC = imax(1, ns_to_cyc(T_ACC_NS, CLK_NS));
    localparam int OE_CYC  = imin(ACC_CYC, imax(1, ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int DF_CYC  = imax(1, ns_to_cyc(T_DF_NS, CLK_NS));
    localparam int G_DLY   = ACC_CYC - OE_CYC;

    logic [15:0] ce_lo_cnt, oe_lo_cnt, ce_hi_cnt;

    // Tracks how long each enable has stayed in its current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_lo_cnt <= '0;
            oe_lo_cnt <= '0;
            ce_hi_cnt <= 16'hFFFF;
        end else begin
            ce_lo_cnt <= mem_ce_n_o ? 16'd0 : ((ce_lo_cnt == 16'hFFFF) ? ce_lo_cnt : ce_lo_cnt + 16'd1);
            oe_lo_cnt <= mem_oe_n_o ? 16'd0 : ((oe_lo_cnt == 16'hFFFF) ? oe_lo_cnt : oe_lo_cnt + 16'd1);
            ce_hi_cnt <= !mem_ce_n_o ? 16'd0 : ((ce_hi_cnt == 16'hFFFF) ? ce_hi_cnt : ce_hi_cnt + 16'd1);
        end
    end

    p_idle_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n_o && mem_oe_n_o && !busy_o && !rvalid_o));

    p_gate_in_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_ce_n_o);

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> (!mem_ce_n_o && busy_o && mem_addr_o == $past(addr_i)));

    p_gate_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n_o) |-> (ce_lo_cnt == 16'(G_DLY)));

    p_access_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (ce_lo_cnt >= 16'(ACC_CYC) && oe_lo_cnt >= 16'(OE_CYC)
                      && mem_ce_n_o && mem_oe_n_o));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

    p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n_o) |-> (ce_hi_cnt >= 16'(DF_CYC + 1)));

    p_busy_in_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> busy_o);

    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mem_ce_n_o) |=> mem_ce_n_o || !$past(busy_o) || !busy_o);

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> $stable(rdata_o));

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLK_NS   (CLK_NS),
    .T_ACC_NS (T_ACC_NS),
    .T_OE_NS  (T_OE_NS),
    .T_DF_NS  (T_DF_NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .addr_i     (addr_i),
    .busy_o     (busy_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .mem_addr_o (mem_addr_o),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_oe_n_o (mem_oe_n_o),
    .mem_q_i    (mem_q_i)
);

// File: tb/sim_eprom_rd_ctrl.sv
`timescale 1ns/1ps
// Bench: reads every address through a timed device model, then holds a
// second request through a whole read to test the hand-off.
module sim_eprom_rd_ctrl;

    localparam int CLK_NS = 10;
    localparam int T_ACC  = 145;
    localparam int T_OE   = 55;
    localparam int T_DF   = 35;
    localparam int ACC    = (T_ACC + CLK_NS - 1) / CLK_NS;
    localparam int OE     = (T_OE + CLK_NS - 1) / CLK_NS;
    localparam int DF     = (T_DF + CLK_NS - 1) / CLK_NS;
    localparam int GD     = ACC - OE;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [11:0] addr;
    logic        busy;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [11:0] maddr;
    logic        ce_n;
    logic        oe_n;
    logic [7:0]  mq = 8'h00;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    eprom_rd_ctrl #(
        .ADDR_W   (12),
        .DATA_W   (8),
        .CLK_NS   (CLK_NS),
        .T_ACC_NS (T_ACC),
        .T_OE_NS  (T_OE),
        .T_DF_NS  (T_DF)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .addr_i     (addr),
        .busy_o     (busy),
        .rdata_o    (rdata),
        .rvalid_o   (rvalid),
        .mem_addr_o (maddr),
        .mem_ce_n_o (ce_n),
        .mem_oe_n_o (oe_n),
        .mem_q_i    (mq)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] word(input int a);
        return 8'((a * 37 + (a >> 4) + 90) & 255);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Device model: drives the right byte only once every timing has elapsed
    // by the next rising edge, a wrong byte if read too early.
    time t_ce = 0, t_oe = 0, t_ad = 0;
    always @(negedge ce_n) t_ce = $time;
    always @(negedge oe_n) t_oe = $time;
    always @(maddr)        t_ad = $time;
    always @(negedge clk) begin
        if (!ce_n && !oe_n) begin
            if (($time + 5 - t_ce) >= T_ACC && ($time + 5 - t_ad) >= T_ACC
                && ($time + 5 - t_oe) >= T_OE)
                mq = word(int'(maddr));
            else
                mq = ~word(int'(maddr));
        end else begin
            mq = 8'h00;
        end
    end

    // One read from an idle negedge; measures every phase at the ports.
    task automatic one_read(input logic [11:0] a);
        int oe_k = 0, rv_k = 0, free_k = 0, nrv = 0;
        bit gate_bad = 0, addr_bad = 0, en_bad = 0;
        logic [7:0] got = 8'h00;
        req  = 1'b1;
        addr = a;
        @(negedge clk);
        req  = 1'b0;
        addr = ~a;
        chk(!ce_n && busy && maddr == a, "R3 accept", int'(maddr), int'(a));
        for (int k = 1; k <= ACC + DF + 4 && free_k == 0; k++) begin
            if (k > 1) @(negedge clk);
            if (!oe_n && ce_n) gate_bad = 1;
            if (!oe_n && oe_k == 0) oe_k = k;
            if (rvalid) begin
                nrv++;
                if (rv_k == 0) begin
                    rv_k = k;
                    got  = rdata;
                    if (!ce_n || !oe_n) en_bad = 1;
                end
            end
            if (maddr != a) addr_bad = 1;
            if (!busy) free_k = k;
        end
        chk(!gate_bad, "R2 gate outside select", int'(gate_bad), 0);
        chk(oe_k == GD + 1, "R4 gate lag", oe_k, GD + 1);
        chk(rv_k == ACC + 1, "R5 strobe cycle", rv_k, ACC + 1);
        chk(nrv == 1, "R5 strobe count", nrv, 1);
        chk(got == word(int'(a)), "R5 data", int'(got), int'(word(int'(a))));
        chk(!en_bad, "R5 enables high at strobe", int'(en_bad), 0);
        chk(!addr_bad, "R6 address hold", int'(addr_bad), 0);
        chk(free_k == ACC + DF + 1, "R7 float window", free_k, ACC + DF + 1);
        chk(rdata == got, "R9 data held", int'(rdata), int'(got));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int fall_k, rv_k;
        bit addr_bad, held_bad;
        logic [11:0] a_first, b_next;
        rst_n = 1'b0;
        req   = 1'b0;
        addr  = 12'h000;
        repeat (3) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        chk(ce_n && oe_n && !busy && !rvalid && rdata == 8'h00, "R1 in reset",
            int'({ce_n, oe_n, busy, rvalid}), 12);
        req   = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n && oe_n && !busy && !rvalid && rdata == 8'h00, "R1 after reset",
            int'({ce_n, oe_n, busy, rvalid}), 12);

        // Sweep every address.
        for (int a = 0; a < 4096; a++) begin
            one_read(12'(a));
        end

        // Held request colliding with the strobe and the last float cycle.
        a_first  = 12'h5A3;
        b_next   = 12'hC3E;
        fall_k   = 0;
        rv_k     = 0;
        addr_bad = 0;
        held_bad = 0;
        req  = 1'b1;
        addr = a_first;
        @(negedge clk);
        addr = b_next;
        for (int k = 1; k <= ACC + DF + 6 && fall_k == 0; k++) begin
            if (k > 1) @(negedge clk);
            if (rvalid && rv_k == 0) begin
                rv_k = k;
                chk(rdata == word(int'(a_first)), "R8 first data kept",
                    int'(rdata), int'(word(int'(a_first))));
            end
            if (k > ACC && !ce_n) fall_k = k;
            else if (maddr != a_first) addr_bad = 1;
        end
        req = 1'b0;
        chk(rv_k == ACC + 1, "R8 strobe with pending request", rv_k, ACC + 1);
        chk(!addr_bad, "R8 address unchanged while busy", int'(addr_bad), 0);
        chk(fall_k == ACC + DF + 2, "R7 select gap before held request", fall_k, ACC + DF + 2);
        chk(maddr == b_next, "R8 held request taken", int'(maddr), int'(b_next));
        for (int k = 1; k <= ACC + 2 && !rvalid; k++) begin
            if (rdata != word(int'(a_first))) held_bad = 1;
            @(negedge clk);
        end
        chk(!held_bad, "R9 data held until next strobe", int'(held_bad), 0);
        chk(rvalid && rdata == word(int'(b_next)), "R5 second data",
            int'(rdata), int'(word(int'(b_next))));
        repeat (DF + 2) @(negedge clk);
        chk(!busy && ce_n && oe_n, "R7 idle after float", int'(busy), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule